// File: doc/BRIEF.md
# Bus Cycle Sequencer with Halt, Retry and Single-Step

This block issues the external bus cycles of a processor-style bus master, one at a time. The core hands it a request (address, function code, size, direction, write data). The sequencer then asserts both strobes and holds them until the external side acknowledges termination. The halt and bus-error inputs are looked at only on the clock edge that carries that acknowledge. Halt alone lets the running cycle finish and then stops any new cycle from starting. Halt together with bus error drops the strobes and later runs the same cycle again.

While the block is stopped, an external master may take the bus. A grant is given only between cycles. While the grant is held, the address, control and strobe outputs are released to high impedance. When the bus comes back, they are driven again with the values that were held. Pulsing halt low and then high again lets exactly one more cycle through, which gives a single-step mode for debug. Interrupts are not accepted while the block is stopped, but a pending indication still follows the request line.

Top module: `bus_step_seq`

## Requirements
- R1: A synchronous reset (rst high) leaves the block idle: both strobes low, ctl_oe and strobe_oe high, arb_grant low, halted low, req_ready high.
- R2: A request accepted on a clock edge (req_valid and req_ready both high) shows up after that edge. Both strobes are high, bus_addr, bus_fc and bus_size carry the request's fields, and bus_read is the inverse of req_write. data_oe is high only for a write, and bus_wdata then carries the write data.
- R3: A cycle in progress ends only on an edge where term_ack is high. Halt or bus error seen without term_ack has no effect, so the strobes stay high.
- R4: On term_ack with ext_halt high and ext_berr low, the cycle completes and rsp_done pulses for one clock. The block then becomes halted: both strobes are driven low with strobe_oe high, data_oe is low and req_ready is low.
- R5: While halted and not granted, bus_addr, bus_fc, bus_size and bus_read keep the values of the last cycle, with ctl_oe high.
- R6: Once halted, dropping ext_halt for one clock and raising it again lets exactly one further cycle start and complete. After that the block stays halted and accepts no request.
- R7: arb_req is granted on the edge after it is seen only when no cycle is running, and never while the strobes are high. While arb_grant is high, ctl_oe, strobe_oe and data_oe are low and req_ready is low.
- R8: When arb_req drops while ext_halt is still high, arb_grant falls, ctl_oe returns high with the previously held address and control values, and halted stays high.
- R9: On term_ack with ext_halt and ext_berr both high, rsp_done stays low, the strobes are driven low, and halted goes high. After ext_halt drops (and the bus is owned), the same cycle runs again with the same address, with no new request. This repeats as often as retry is signalled.
- R10: On term_ack with ext_berr high and ext_halt low, the cycle ends with rsp_done and rsp_err both high for one clock.
- R11: irq_ack equals irq_req only while not halted. irq_pend follows irq_req at all times.
- R12: A read cycle captures bus_rdata on its terminating edge into rsp_rdata, which holds until the next completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Sequencer can take a request this edge |
| req_addr | input | AW | Request address |
| req_fc | input | FCW | Request function code |
| req_size | input | SW | Request transfer size |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-clock pulse when a cycle completes |
| rsp_err | output | 1 | With rsp_done: cycle ended by bus error |
| rsp_rdata | output | DW | Last read data |
| halted | output | 1 | Stopped by halt or awaiting retry |
| ext_halt | input | 1 | External halt, active high |
| ext_berr | input | 1 | External bus error, active high |
| term_ack | input | 1 | Cycle termination acknowledge |
| arb_req | input | 1 | Another master requests the bus |
| arb_grant | output | 1 | Bus handed to the other master |
| bus_addr | output | AW | Address lines |
| bus_fc | output | FCW | Function code lines |
| bus_size | output | SW | Size lines |
| bus_read | output | 1 | Direction, 1 = read |
| ctl_oe | output | 1 | Output enable for address, function code, size, direction |
| addr_strobe | output | 1 | Address strobe, 1 = asserted |
| data_strobe | output | 1 | Data strobe, 1 = asserted |
| strobe_oe | output | 1 | Output enable for both strobes |
| bus_wdata | output | DW | Write data lines |
| data_oe | output | 1 | Output enable for data lines |
| bus_rdata | input | DW | Read data lines |
| irq_req | input | 1 | Interrupt request |
| irq_ack | output | 1 | Interrupt accepted |
| irq_pend | output | 1 | Interrupt pending indication |

## Verification
The assertions assume that term_ack arrives only while a cycle is running and that the halt and bus-error levels present on that edge are the ones that matter. The stimulus raises term_ack only after the strobes have been seen high, for exactly one clock. It changes inputs only on the falling edge, so every level is stable at the sampling edge. The assertions also assume that arb_req is not raised in the same clock as a new request is accepted. The stimulus raises arb_req only when the block is halted, or when a cycle is already running.

// File: rtl/bus_step_seq.sv
module bus_step_seq #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int FCW = 3,
  parameter int SW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [FCW-1:0] req_fc,
  input  logic [SW-1:0]  req_size,
  input  logic           req_write,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_done,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic           halted,
  input  logic           ext_halt,
  input  logic           ext_berr,
  input  logic           term_ack,
  input  logic           arb_req,
  output logic           arb_grant,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic [SW-1:0]  bus_size,
  output logic           bus_read,
  output logic           ctl_oe,
  output logic           addr_strobe,
  output logic           data_strobe,
  output logic           strobe_oe,
  output logic [DW-1:0]  bus_wdata,
  output logic           data_oe,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           irq_req,
  output logic           irq_ack,
  output logic           irq_pend
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT, ST_RETRY} st_t;

  st_t           st;
  logic          grant_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [FCW-1:0] fc_q;
  logic [SW-1:0] size_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q, err_q;
  logic          past_ok;

  wire running = (st == ST_RUN);

  assign req_ready   = (st == ST_IDLE) && !grant_q && !arb_req;
  assign halted      = (st == ST_HALT) || (st == ST_RETRY);
  assign arb_grant   = grant_q;
  assign bus_addr    = addr_q;
  assign bus_fc      = fc_q;
  assign bus_size    = size_q;
  assign bus_read    = !wr_q;
  assign bus_wdata   = wdata_q;
  assign ctl_oe      = !grant_q;
  assign strobe_oe   = !grant_q;
  assign addr_strobe = running;
  assign data_strobe = running;
  assign data_oe     = running && wr_q && !grant_q;
  assign rsp_done    = done_q;
  assign rsp_err     = err_q;
  assign rsp_rdata   = rdata_q;
  assign irq_pend    = irq_req;
  assign irq_ack     = irq_req && !halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      grant_q <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      fc_q    <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      if (st != ST_RUN) grant_q <= arb_req;
      case (st)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            addr_q  <= req_addr;
            fc_q    <= req_fc;
            size_q  <= req_size;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            st      <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (term_ack) begin
            if (ext_halt && ext_berr) begin
              st <= ST_RETRY;
            end else begin
              done_q <= 1'b1;
              err_q  <= ext_berr;
              if (!wr_q) rdata_q <= bus_rdata;
              st <= ext_halt ? ST_HALT : ST_IDLE;
            end
          end
        end
        ST_HALT: begin
          if (!ext_halt) st <= ST_IDLE;
        end
        ST_RETRY: begin
          if (!ext_halt && !grant_q && !arb_req) st <= ST_RUN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe && !term_ack) |=> addr_strobe);

  // R4
  halt_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe && term_ack && ext_halt && !ext_berr) |=> (halted && rsp_done && !addr_strobe && strobe_oe));

  // R9
  retry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe && term_ack && ext_halt && ext_berr) |=> (!rsp_done && halted && !addr_strobe));

  // R7
  grant_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_grant) |-> !$past(addr_strobe));

  // R7
  grant_release_chk: assert property (@(posedge clk) disable iff (rst)
    arb_grant |-> (!addr_strobe && !data_oe && !req_ready));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && halted && $past(halted)) |-> ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_read)));

  // R11
  irq_block_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !irq_ack);

  // R10
  berr_end_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe && term_ack && ext_berr && !ext_halt) |=> (rsp_done && rsp_err && !halted));

endmodule

// File: tb/bus_step_seq_bench.sv
module bus_step_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, FCW = 3, SW = 2;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [FCW-1:0] req_fc;
  logic [SW-1:0] req_size;
  logic [DW-1:0] req_wdata;
  logic rsp_done, rsp_err, halted;
  logic [DW-1:0] rsp_rdata;
  logic ext_halt, ext_berr, term_ack, arb_req, arb_grant;
  logic [AW-1:0] bus_addr;
  logic [FCW-1:0] bus_fc;
  logic [SW-1:0] bus_size;
  logic bus_read, ctl_oe, addr_strobe, data_strobe, strobe_oe, data_oe;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic irq_req, irq_ack, irq_pend;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_step_seq #(.AW(AW), .DW(DW), .FCW(FCW), .SW(SW)) u_bus_step_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_fc(req_fc), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .halted(halted),
    .ext_halt(ext_halt), .ext_berr(ext_berr), .term_ack(term_ack),
    .arb_req(arb_req), .arb_grant(arb_grant),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_size(bus_size), .bus_read(bus_read),
    .ctl_oe(ctl_oe), .addr_strobe(addr_strobe), .data_strobe(data_strobe),
    .strobe_oe(strobe_oe), .bus_wdata(bus_wdata), .data_oe(data_oe), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_pend(irq_pend)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start_req(input logic [AW-1:0] a, input logic [FCW-1:0] fc,
                           input logic [SW-1:0] sz, input logic wr, input logic [DW-1:0] wd);
    req_addr = a; req_fc = fc; req_size = sz; req_write = wr; req_wdata = wd;
    req_valid = 1'b1;
    chk("R2 ready before request", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic end_cycle(input logic h, input logic b);
    ext_halt = h; ext_berr = b; term_ack = 1'b1;
    @(negedge clk);
    term_ack = 1'b0; ext_berr = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobe", {addr_strobe, data_strobe}, 0);
    chk("R1 oe", {ctl_oe, strobe_oe}, 2'b11);
    chk("R1 grant/halted", {arb_grant, halted}, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_write;
    start_req(32'h1000_0040, 3'd5, 2'd2, 1'b1, 32'hCAFE_0001);
    chk("R2 strobes", {addr_strobe, data_strobe}, 2'b11);
    chk("R2 addr", bus_addr, 32'h1000_0040);
    chk("R2 fc/size/read", {bus_fc, bus_size, bus_read}, {3'd5, 2'd2, 1'b0});
    chk("R2 data", {data_oe, bus_wdata}, {1'b1, 32'hCAFE_0001});
    ext_halt = 1'b1; ext_berr = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 no end without ack", {addr_strobe, rsp_done, halted}, 3'b100);
    ext_halt = 1'b0; ext_berr = 1'b0;
    end_cycle(1'b0, 1'b0);
    chk("R10 normal end", {rsp_done, rsp_err, addr_strobe, req_ready}, 4'b1001);
  endtask

  task automatic t_read;
    start_req(32'h0000_0200, 3'd1, 2'd0, 1'b0, 32'hFFFF_FFFF);
    chk("R2 read no data_oe", {data_oe, bus_read}, 2'b01);
    bus_rdata = 32'h1234_5678;
    end_cycle(1'b0, 1'b0);
    bus_rdata = 32'h0;
    @(negedge clk);
    chk("R12 read data", rsp_rdata, 32'h1234_5678);
  endtask

  task automatic t_halt_step;
    start_req(32'hA000_0004, 3'd6, 2'd1, 1'b1, 32'h55);
    end_cycle(1'b1, 1'b0);
    chk("R4 done on halt", rsp_done, 1);
    chk("R4 halted strobes", {halted, addr_strobe, data_strobe, strobe_oe, data_oe}, 5'b10010);
    req_valid = 1'b1; req_addr = 32'hDEAD_0000;
    chk("R4 not ready", req_ready, 0);
    irq_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 hold addr", {ctl_oe, bus_addr}, {1'b1, 32'hA000_0004});
    chk("R5 hold ctl", {bus_fc, bus_size, bus_read}, {3'd6, 2'd1, 1'b0});
    chk("R11 irq blocked", {irq_ack, irq_pend}, 2'b01);
    req_valid = 1'b0; irq_req = 1'b0;
    ext_halt = 1'b0;
    @(negedge clk);
    ext_halt = 1'b1;
    chk("R6 released", halted, 0);
    start_req(32'hB000_0008, 3'd2, 2'd3, 1'b0, 32'h0);
    chk("R6 one cycle runs", {addr_strobe, bus_addr}, {1'b1, 32'hB000_0008});
    end_cycle(1'b1, 1'b0);
    req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R6 no second cycle", {halted, addr_strobe, req_ready}, 3'b100);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_grant_halted;
    arb_req = 1'b1;
    @(negedge clk);
    chk("R7 granted", {arb_grant, ctl_oe, strobe_oe, data_oe}, 4'b1000);
    arb_req = 1'b0;
    @(negedge clk);
    chk("R8 returned", {arb_grant, ctl_oe, halted}, 3'b011);
    chk("R8 addr restored", bus_addr, 32'hB000_0008);
    ext_halt = 1'b0;
    @(negedge clk);
    irq_req = 1'b1;
    #1;
    chk("R11 irq taken", irq_ack, 1);
    irq_req = 1'b0;
  endtask

  task automatic t_grant_in_cycle;
    start_req(32'hC000_0010, 3'd5, 2'd0, 1'b1, 32'h77);
    arb_req = 1'b1;
    @(negedge clk);
    chk("R7 no grant in cycle", {arb_grant, addr_strobe}, 2'b01);
    end_cycle(1'b0, 1'b0);
    chk("R7 not yet", arb_grant, 0);
    @(negedge clk);
    chk("R7 grant after cycle", {arb_grant, req_ready}, 2'b10);
    arb_req = 1'b0;
    @(negedge clk);
    chk("R7 grant dropped", {arb_grant, req_ready}, 2'b01);
  endtask

  task automatic t_retry;
    start_req(32'hD000_0020, 3'd1, 2'd2, 1'b0, 32'h0);
    for (int k = 0; k < 2; k++) begin
      end_cycle(1'b1, 1'b1);
      chk("R9 no done", {rsp_done, addr_strobe, halted}, 3'b001);
      @(negedge clk);
      ext_halt = 1'b0;
      @(negedge clk);
      chk("R9 rerun", {addr_strobe, bus_addr}, {1'b1, 32'hD000_0020});
      chk("R9 no new req", req_ready, 0);
    end
    end_cycle(1'b0, 1'b0);
    chk("R9 final done", {rsp_done, rsp_err}, 2'b10);
  endtask

  task automatic t_berr;
    start_req(32'hE000_0000, 3'd5, 2'd1, 1'b1, 32'h9);
    end_cycle(1'b0, 1'b1);
    chk("R10 berr end", {rsp_done, rsp_err, halted}, 3'b110);
    @(negedge clk);
    chk("R10 pulse", {rsp_done, rsp_err}, 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_addr = 0; req_fc = 0; req_size = 0; req_write = 0;
    req_wdata = 0; ext_halt = 0; ext_berr = 0; term_ack = 0; arb_req = 0;
    bus_rdata = 0; irq_req = 0;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_halt_step();
    t_grant_halted();
    t_grant_in_cycle();
    t_retry();
    t_berr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule